// File: doc/BRIEF.md
# I2C Receive Burst Engine

This block runs the data phase of a multi-byte I2C master read and lands every byte in a receive FIFO. Software writes one control register with a byte count and a flag that says whether the final byte gets a NAK. The write starts the burst at once. The engine then asks an external SCL/SDA bit shifter for bits one at a time. It releases SDA for the eight data bits of each byte, assembles the byte MSB first, and then drives the acknowledge bit. START, STOP and address phases are handled elsewhere.

Because ACK or NAK on the last byte is chosen per burst, a long read can be split into FIFO-sized pieces. Each piece except the final one ends with an ACK, so the slave keeps sending. When a burst has stored all of its bytes, a read-complete status bit is set and can raise an interrupt. Software drains bytes by popping the FIFO, and an empty flag shows when nothing is left. If the FIFO is full at the point where a new byte would start, the engine holds off the bus until a pop frees a slot.

The bit interface is a simple handshake. While `bit_req` is high, the shifter performs one bus bit. It drives SDA released when `bit_drive` is 1 and low when it is 0. It pulses `bit_done` for one cycle when the bit is finished, with the sampled SDA value on `bit_rx`.

Top module: `i2c_rx_burst`

## Requirements
- R1: After reset the engine is idle: `bit_req` and `irq` are 0, status bit 4 is 0, and FIFO status bit 2 (empty) is 1.
- R2: A write with `reg_addr`=0 while idle starts a burst. Byte count is `reg_wdata[6:0]` and NAK-last is `reg_wdata[7]`. A count above 64 is treated as 64.
- R3: During the eight data bits of a byte, `bit_drive` is 1 (SDA released). The byte is assembled from `bit_rx` with the first bit as the MSB.
- R4: On the acknowledge bit (ninth bit), `bit_drive` is 0 for every byte except the last byte of the burst. For the last byte, `bit_drive` equals the burst's NAK-last flag.
- R5: Status bit 4 (read-complete) is set on the clock edge where the last byte's acknowledge bit completes. A count of 0 sets it on the edge of the control write, with no `bit_req`.
- R6: A write with `reg_addr`=2 and `reg_wdata[4]`=1 clears read-complete. A completion on the same edge wins. The bit is not set again until another burst completes.
- R7: `irq` is 1 exactly when read-complete is 1 and the interrupt enable is 1. The enable is written as `reg_wdata[4]` with `reg_addr`=1.
- R8: `rd_data` shows the oldest stored byte. A `fifo_pop` removes it. FIFO status bit 2 is 1 exactly when the FIFO is empty.
- R9: With the FIFO empty, `rd_data` is 0 and a `fifo_pop` leaves the FIFO unchanged.
- R10: When the FIFO holds 64 bytes, the engine does not raise `bit_req` for a new byte until a pop makes room. The next byte then proceeds normally.
- R11: A control write (`reg_addr`=0) while a burst is running is ignored: the running burst keeps its count and NAK-last flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 interrupt enable, 2 status clear |
| reg_wdata | input | 8 | Register write data |
| fifo_pop | input | 1 | Pop the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte, 0 when empty |
| fifo_status | output | 8 | Bit 2: FIFO empty |
| status_q | output | 8 | Bit 4: read-complete |
| irq | output | 1 | Interrupt request |
| bit_req | output | 1 | Request one bus bit from the shifter |
| bit_drive | output | 1 | SDA value for the requested bit (1 = release) |
| bit_done | input | 1 | Shifter finished the requested bit |
| bit_rx | input | 1 | SDA value sampled for the finished bit |

## Verification
Short bursts ending in a NAK, with the shifter answering every cycle, separate correct MSB-first assembly and last-byte NAK from off-by-one bit counting. Longer bursts with NAK-last clear run with a slow, stalling shifter. Those runs also receive a second control write mid-burst, which shows that every acknowledge is an ACK, that the extra write is ignored, and that handshake stalls do not lose bits. A count above 64 followed by a second burst into the full FIFO exercises the clamp and the hold-off. Zero counts, pops on an empty FIFO and status clears around completions check the flag and interrupt behaviour against a cycle-level reference model.

// File: rtl/i2c_rxb_pkg.sv
package i2c_rxb_pkg;
   // register select codes on reg_addr
   typedef enum logic [1:0] {
      SEL_RDCTL = 2'd0,
      SEL_IEN   = 2'd1,
      SEL_STAT  = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   // bit positions software depends on
   localparam int NAK_POS   = 7;  // control: NAK-last flag, count below it
   localparam int DONE_POS  = 4;  // status / enable: read-complete
   localparam int EMPTY_POS = 2;  // FIFO status: empty
   localparam int REG_W     = 8;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wnext, rnext;
   logic [AW:0]   fill;
   logic          do_push, do_pop;

   assign empty   = (fill == '0);
   assign full    = (fill == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = empty ? '0 : mem[rptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wnext = (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/rxb_shifter.sv
module rxb_shifter #(
   parameter int W     = 8,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs,
   input  logic             bit_rx,
   output logic [IDX_W-1:0] idx,
   output logic             ack_phase,
   output logic             byte_done,
   output logic [W-1:0]     byte_q
);
   assign ack_phase = (idx == IDX_W'(W));
   assign byte_done = hs && ack_phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx    <= '0;
         byte_q <= '0;
      end else if (hs) begin
         if (ack_phase) begin
            idx <= '0;
         end else begin
            idx    <= idx + 1'b1;
            byte_q <= {byte_q[W-2:0], bit_rx};
         end
      end
   end
endmodule

// File: rtl/rxb_seq.sv
module rxb_seq #(
   parameter int DEPTH   = 64,
   parameter int FIELD_W = 7,
   parameter int CNT_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_wr,
   input  logic [FIELD_W-1:0] req_count,
   input  logic               req_nak,
   input  logic               byte_done,
   output logic               busy,
   output logic               last,
   output logic               nak_last,
   output logic               done_set,
   output logic [CNT_W-1:0]   left
);
   logic [CNT_W-1:0] clamped;
   logic             accept;

   always_comb begin
      if (int'(req_count) > DEPTH) clamped = CNT_W'(DEPTH);
      else                         clamped = CNT_W'(req_count);
   end

   assign accept   = start_wr && !busy;
   assign last     = (left == CNT_W'(1));
   assign done_set = (accept && (clamped == '0)) || (byte_done && last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         left     <= '0;
         nak_last <= 1'b0;
      end else if (accept && (clamped != '0)) begin
         busy     <= 1'b1;
         left     <= clamped;
         nak_last <= req_nak;
      end else if (byte_done) begin
         left <= left - 1'b1;
         if (last) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_rx_burst.sv
module i2c_rx_burst
   import i2c_rxb_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 64,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              fifo_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic [REG_W-1:0]  fifo_status,
   output logic [REG_W-1:0]  status_q,
   output logic              irq,
   output logic              bit_req,
   output logic              bit_drive,
   input  logic              bit_done,
   input  logic              bit_rx
);
   localparam int FIELD_W = NAK_POS;
   localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
   localparam int IDX_W   = $clog2(DATA_W + 1);

   generate
      if (FIFO_DEPTH < 2 || FIFO_DEPTH > (1 << FIELD_W) - 1) begin : g_bad_depth
         $error("FIFO_DEPTH must fit the count field");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic             busy, last_b, nak_last, done_set;
   logic [CNT_W-1:0] left_cnt;
   logic [IDX_W-1:0] bit_idx;
   logic             ack_phase, push;
   logic [DATA_W-1:0] byte_q;
   logic             fifo_empty, fifo_full;
   logic             rc_q, ien_q, hs;
   logic             ctl_wr, ien_wr, clr_wr;

   assign ctl_wr = reg_wr && (reg_addr == SEL_RDCTL);
   assign ien_wr = reg_wr && (reg_addr == SEL_IEN);
   assign clr_wr = reg_wr && (reg_addr == SEL_STAT) && reg_wdata[DONE_POS];

   assign bit_req   = busy && !((bit_idx == '0) && fifo_full);
   assign bit_drive = ack_phase ? (last_b && nak_last) : 1'b1;
   assign hs        = bit_req && bit_done;

   rxb_seq #(
      .DEPTH   (FIFO_DEPTH),
      .FIELD_W (FIELD_W),
      .CNT_W   (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_wr  (ctl_wr),
      .req_count (reg_wdata[FIELD_W-1:0]),
      .req_nak   (reg_wdata[NAK_POS]),
      .byte_done (push),
      .busy      (busy),
      .last      (last_b),
      .nak_last  (nak_last),
      .done_set  (done_set),
      .left      (left_cnt)
   );

   rxb_shifter #(
      .W     (DATA_W),
      .IDX_W (IDX_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs        (hs),
      .bit_rx    (bit_rx),
      .idx       (bit_idx),
      .ack_phase (ack_phase),
      .byte_done (push),
      .byte_q    (byte_q)
   );

   rxb_fifo #(
      .W     (DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (byte_q),
      .pop       (fifo_pop),
      .head      (rd_data),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rc_q  <= 1'b0;
         ien_q <= 1'b0;
      end else begin
         if (done_set)    rc_q <= 1'b1;
         else if (clr_wr) rc_q <= 1'b0;
         if (ien_wr) ien_q <= reg_wdata[DONE_POS];
      end
   end

   always_comb begin
      status_q              = '0;
      status_q[DONE_POS]    = rc_q;
      fifo_status           = '0;
      fifo_status[EMPTY_POS] = fifo_empty;
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= rc_q && ien_q;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = rc_q && ien_q;
      end
   endgenerate
endmodule

// File: rtl/i2c_rx_burst_chk.sv
module i2c_rx_burst_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 4,
   parameter int CNT_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              fifo_pop,
   input logic [DATA_W-1:0] rd_data,
   input logic [7:0]        fifo_status,
   input logic [7:0]        status_q,
   input logic              irq,
   input logic              bit_req,
   input logic              bit_drive,
   input logic              busy,
   input logic              last_b,
   input logic [IDX_W-1:0]  bit_idx,
   input logic              push,
   input logic              fifo_full,
   input logic [CNT_W-1:0]  left_cnt
);
   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !fifo_full);
   // R3
   data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req && bit_idx < IDX_W'(DATA_W)) |-> bit_drive);
   // R4
   ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req && bit_idx == IDX_W'(DATA_W) && !last_b) |-> !bit_drive);
   // R6
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q[4]) |-> $past(reg_wr && reg_addr == 2'd2 && reg_wdata[4]));
   // R7
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status_q[4]);
   // R9
   empty_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_status[2] |-> rd_data == '0);
   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && fifo_status[2] && !push) |=> fifo_status[2]);
   // R11
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == 2'd0 && !push) |=> left_cnt == $past(left_cnt));
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bit_req);
endmodule

bind i2c_rx_burst i2c_rx_burst_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .fifo_pop    (fifo_pop),
   .rd_data     (rd_data),
   .fifo_status (fifo_status),
   .status_q    (status_q),
   .irq         (irq),
   .bit_req     (bit_req),
   .bit_drive   (bit_drive),
   .busy        (busy),
   .last_b      (last_b),
   .bit_idx     (bit_idx),
   .push        (push),
   .fifo_full   (fifo_full),
   .left_cnt    (left_cnt)
);

// File: tb/i2c_rx_burst_bench.sv
module i2c_rx_burst_bench;
   localparam int DEPTH = 64;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, fifo_pop = 1'b0, bit_done = 1'b0, bit_rx = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] rd_data, fifo_status, status_q;
   logic       irq, bit_req, bit_drive;

   i2c_rx_burst u_i2c_rx_burst (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .fifo_pop(fifo_pop), .rd_data(rd_data),
      .fifo_status(fifo_status), .status_q(status_q), .irq(irq),
      .bit_req(bit_req), .bit_drive(bit_drive), .bit_done(bit_done),
      .bit_rx(bit_rx)
   );

   int total = 0, bad = 0;
   bit finished = 0;

   // reference model state
   bit       m_busy = 0, m_nak = 0, m_rc = 0, m_ie = 0;
   int       m_left = 0, m_bit = 0, m_total = 0;
   bit [7:0] m_q[$];
   int       stall = 1, tick = 0;

   function automatic bit [7:0] slave_byte(input int k);
      return 8'((k * 37 + 91) & 255);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit wr = 0, input bit [1:0] a = 0,
                      input bit [7:0] d = 0, input bit pop = 0);
      bit eq, hs, rxb, set_rc, was_busy;
      bit [7:0] sb;
      int sz, c;
      sz = m_q.size();
      was_busy = m_busy;
      eq = m_busy && !(m_bit == 0 && sz == DEPTH);
      chk("R2/R10 bit_req", bit_req, eq);
      if (eq) begin
         if (m_bit < 8) chk("R3 data bit release", bit_drive, 1);
         else           chk("R4 ack drive", bit_drive, (m_left == 1) ? m_nak : 0);
      end
      chk("R8 rd_data", rd_data, sz > 0 ? m_q[0] : 0);
      chk("R8 empty flag", fifo_status[2], sz == 0);
      chk("R5 done flag", status_q[4], m_rc);
      chk("R7 irq", irq, m_rc && m_ie);
      tick++;
      hs = eq && (tick % stall == 0);
      sb = slave_byte(m_total);
      rxb = (m_bit < 8) ? sb[7 - m_bit] : 1'b0;
      bit_done = hs; bit_rx = rxb;
      reg_wr = wr; reg_addr = a; reg_wdata = d; fifo_pop = pop;
      if (pop && sz > 0) void'(m_q.pop_front());
      set_rc = 0;
      if (hs) begin
         if (m_bit < 8) m_bit++;
         else begin
            m_q.push_back(sb);
            m_total++;
            m_bit = 0;
            m_left--;
            if (m_left == 0) begin m_busy = 0; set_rc = 1; end
         end
      end
      if (wr && a == 2'd0 && !was_busy) begin
         c = int'(d[6:0]);
         if (c > DEPTH) c = DEPTH;
         if (c == 0) set_rc = 1;
         else begin m_busy = 1; m_left = c; m_nak = d[7]; end
      end
      if (wr && a == 2'd1) m_ie = d[4];
      if (set_rc) m_rc = 1;
      else if (wr && a == 2'd2 && d[4]) m_rc = 0;
      @(posedge clk);
      @(negedge clk);
      bit_done = 0; reg_wr = 0; fifo_pop = 0;
   endtask

   task automatic run_idle();
      for (int g = 0; g < 5000 && m_busy; g++) cyc();
   endtask

   task automatic drain(output int n);
      n = 0;
      while (fifo_status[2] == 1'b0 && n < 200) begin
         n++;
         cyc(0, 0, 0, 1);
      end
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 bit_req idle", bit_req, 0);
      chk("R1 irq idle", irq, 0);
      chk("R1 done clear", status_q[4], 0);
      chk("R1 fifo empty", fifo_status[2], 1);

      // 3-byte burst, NAK last, fast shifter, irq enabled
      stall = 1;
      cyc(1, 2'd1, 8'h10);
      cyc(1, 2'd0, 8'h83);
      run_idle();
      cyc();
      chk("R7 irq after burst", irq, 1);
      drain(n);
      chk("R8 three bytes", n, 3);

      // R6 clear, stays clear
      cyc(1, 2'd2, 8'h10);
      repeat (4) cyc();
      chk("R6 cleared", status_q[4], 0);

      // R5 zero count
      cyc(1, 2'd0, 8'h00);
      chk("R5 zero count done", status_q[4], 1);
      chk("R5 zero count no bus", bit_req, 0);
      cyc(1, 2'd2, 8'h10);

      // R11: 5 bytes, ACK all, slow shifter, extra write mid-burst
      stall = 3;
      cyc(1, 2'd0, 8'h05);
      repeat (20) cyc();
      cyc(1, 2'd0, 8'h82);
      cyc(1, 2'd2, 8'h10);
      run_idle();
      drain(n);
      chk("R11 write ignored count", n, 5);

      // R9 pop on empty
      cyc(0, 0, 0, 1);
      chk("R9 empty data", rd_data, 0);
      chk("R9 still empty", fifo_status[2], 1);

      // R2 clamp to 64 then R10 hold-off on a full FIFO
      stall = 1;
      cyc(1, 2'd2, 8'h10);
      cyc(1, 2'd0, 8'hE4);
      run_idle();
      cyc(1, 2'd0, 8'h82);
      repeat (5) cyc();
      chk("R10 held while full", bit_req, 0);
      cyc(0, 0, 0, 1);
      run_idle();
      drain(n);
      chk("R2 clamp total bytes", n + 1, 66);
      cyc(1, 2'd1, 8'h00);
      cyc();
      chk("R7 irq masked", irq, 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule